// File: doc/BRIEF.md
# Per-Pin Interrupt Request and Redelivery Engine

This block is the request side of an I/O interrupt router. Each input pin has one bit of request state, a remote-acknowledge flag for level-triggered pins and a delivered flag for edge-triggered pins. Line level changes come in one at a time. The block decides, from each pin's trigger mode, mask and remote-acknowledge flag, whether the change leads to a delivery. For each line change it returns a one-word result. When a change leads to a delivery, it issues a request that carries the vector, the destination and the destination mode.

End-of-interrupt notices arrive by vector. Every level-triggered pin whose entry uses that vector is released, and it is served again if its line is still high. A per-pin count of back-to-back redeliveries stops interrupt storms. When the count reaches its limit, that pin's redelivery is held back for a fixed number of cycles. When that delay runs out, one sweep serves every level pin that is still waiting. The routing entries themselves (vector, destination, mask, mode) are held outside the block and arrive as flat buses. A pulse tells the block that an entry has been rewritten.

Top module: `irq_pin_engine`

## Requirements
- R1: During and after reset, every request, remote-acknowledge and delivered flag is clear, no delivery is requested and no result is valid.
- R2: A low level on a pin clears its request bit. One cycle later the result is valid with code 0 (success).
- R3: For an edge pin (mode bit 0), a high level while the request bit is already set gives result code 1 (coalesced) and no delivery. Every high level clears the pin's delivered flag, so the bit shows again in `pend_irr` (request AND NOT delivered).
- R4: For a level pin (mode bit 1), a high level while its remote-acknowledge flag is set gives result code 1 (coalesced) and no delivery.
- R5: A masked pin is never delivered. A high level that is not coalesced gives result code 2 (masked). A service still pending when the pin becomes masked is dropped at issue.
- R6: Issuing a level pin sets its remote-acknowledge flag. Issuing an edge pin sets its delivered flag. The request carries that pin's vector, destination, destination mode and trigger mode.
- R7: A service request shows on the delivery port in the cycle after the event that caused it. Pending pins are issued one per cycle, lowest pin number first.
- R8: A level-type, non-directed end-of-interrupt clears the remote-acknowledge flag of every level pin whose vector matches. Each such pin that is unmasked and still requesting is served again.
- R9: An end-of-interrupt that is edge-type, or that is flagged directed, changes no flag and causes no delivery.
- R10: Each pin counts its consecutive end-of-interrupt redeliveries. The STORM_MAX-th one (default 10000) is not issued: it starts the retry delay and zeroes the count. An end-of-interrupt that releases the pin without redelivering it also zeroes the count.
- R11: RETRY_DELAY clock edges after the deferring edge (default 1000), every level pin that is requesting and has no remote-acknowledge flag is served. A deferral while the delay is already running is absorbed into that delay.
- R12: An entry-rewrite pulse clears the pin's remote-acknowledge flag. If the pin is level-triggered and requesting, it is served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_destmode | input | NPINS | Per-pin destination mode bit |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination, pin i at bits i*DEST_W |
| touch_valid | input | 1 | Entry-rewrite pulse |
| touch_pin | input | PIN_W | Pin whose entry was rewritten |
| line_valid | input | 1 | Line level change strobe |
| line_pin | input | PIN_W | Pin of the line change (below NPINS) |
| line_level | input | 1 | New line level |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Acknowledged vector |
| eoi_level | input | 1 | End-of-interrupt is level-type |
| eoi_directed | input | 1 | Acknowledging processor uses directed mode |
| res_valid | output | 1 | Result of the previous cycle's line change |
| res_code | output | 2 | 0 success, 1 coalesced, 2 masked |
| deliv_valid | output | 1 | Delivery request |
| deliv_pin | output | PIN_W | Pin being delivered |
| deliv_vector | output | VEC_W | Vector of the request |
| deliv_dest | output | DEST_W | Destination of the request |
| deliv_destmode | output | 1 | Destination mode of the request |
| deliv_level | output | 1 | Trigger mode of the request |
| pend_irr | output | NPINS | Request bits not yet delivered |
| remote_irr | output | NPINS | Remote-acknowledge flags |

## Verification
The bench drives directed sequences and then a mixed random phase. A behavioural model predicts every output on every clock. Repeated high levels on edge and on level pins show apart the two coalescing rules. Masked, directed and edge-type acknowledges show that a pin is suppressed, not merely delayed. A shared vector on two pins checks ascending issue order. A held line with repeated acknowledges brings up the storm deferral and the sweep that runs when the delay expires. The random phase lets rewrites, acknowledges and line changes collide on the same pin and in the same cycle.

// File: rtl/irq_pin_pkg.sv
// Shared result encoding for the per-pin interrupt request engine.
package irq_pin_pkg;
    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_COALESCED = 2'd1,
        RES_MASKED    = 2'd2
    } res_e;
endpackage

// File: rtl/irq_pin_slot.sv
// One pin's request state: request bit, delivered and remote-acknowledge
// flags, pending-service bit and storm counter.
// Assumes the arbiter grants at most one pin per cycle and that the grant
// is based on svc as it stood before this cycle's events.
module irq_pin_slot
    import irq_pin_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int PIN_W     = 2,
    parameter int VEC_W     = 8,
    parameter int STORM_MAX = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_level,
    input  logic             cfg_mask,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic             line_valid,
    input  logic [PIN_W-1:0] line_pin,
    input  logic             line_level,
    input  logic             touch_valid,
    input  logic [PIN_W-1:0] touch_pin,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic             eoi_directed,
    input  logic             retry_fire,
    input  logic             grant,
    output logic             irr,
    output logic             delivered,
    output logic             remote,
    output logic             svc,
    output logic             defer,
    output res_e             res
);
    localparam int CNT_W = $clog2(STORM_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORM_MAX - 1);

    logic             irr_q, del_q, rem_q, svc_q;
    logic             irr_n, del_n, rem_n, svc_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             line_hit, touch_hit, eoi_hit;

    assign line_hit  = line_valid && (line_pin == PIN_W'(IDX));
    assign touch_hit = touch_valid && (touch_pin == PIN_W'(IDX));
    assign eoi_hit   = eoi_valid && eoi_level && !eoi_directed && cfg_level
                       && (eoi_vector == cfg_vector);

    // Next state: grant first, then line, rewrite, acknowledge, retry sweep.
    always_comb begin
        irr_n = irr_q; del_n = del_q; rem_n = rem_q; svc_n = svc_q;
        cnt_n = cnt_q; defer = 1'b0; res = RES_OK;
        if (grant) begin
            svc_n = 1'b0;
            if (!cfg_mask) begin
                if (cfg_level) rem_n = 1'b1;
                else           del_n = 1'b1;
            end
        end
        if (line_hit) begin
            if (!line_level) begin
                irr_n = 1'b0;
            end else begin
                if (cfg_level ? rem_n : irr_n) res = RES_COALESCED;
                else if (cfg_mask)             res = RES_MASKED;
                else                           svc_n = 1'b1;
                irr_n = 1'b1;
                if (!cfg_level) del_n = 1'b0;
            end
        end
        if (touch_hit) begin
            rem_n = 1'b0;
            if (cfg_level && irr_n) svc_n = 1'b1;
        end
        if (eoi_hit) begin
            rem_n = 1'b0;
            if (!cfg_mask && irr_n) begin
                if (cnt_q == CNT_LAST) begin
                    cnt_n = '0;
                    defer = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                    svc_n = 1'b1;
                end
            end else begin
                cnt_n = '0;
            end
        end
        if (retry_fire && cfg_level && irr_n && !rem_n) svc_n = 1'b1;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= 1'b0; del_q <= 1'b0; rem_q <= 1'b0; svc_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            irr_q <= irr_n; del_q <= del_n; rem_q <= rem_n; svc_q <= svc_n;
            cnt_q <= cnt_n;
        end
    end

    assign irr       = irr_q;
    assign delivered = del_q;
    assign remote    = rem_q;
    assign svc       = svc_q;

    // R2
    line_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hit && !line_level) |=> !irr_q);
    // R6
    remote_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rem_q) |-> $past(grant));
    // R9
    remote_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q && !touch_hit && !(eoi_valid && eoi_level && !eoi_directed
         && eoi_vector == cfg_vector)) |=> rem_q);
    // R10
    storm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
endmodule

// File: rtl/irq_pin_arbiter.sv
// Fixed-priority pick of the lowest pending pin.
// Assumes req is a registered vector; output is purely combinational.
module irq_pin_arbiter #(
    parameter int NPINS = 8,
    parameter int PIN_W = 3
) (
    input  logic [NPINS-1:0] req,
    output logic [NPINS-1:0] gnt,
    output logic             any,
    output logic [PIN_W-1:0] idx
);
    // Scan from the top down so the lowest requester wins.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                any = 1'b1;
                idx = PIN_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_retry_timer.sv
// Down-counter for the deferred storm retry; emits a one-cycle fire pulse
// DELAY edges after the start edge. Assumes DELAY >= 2.
module irq_retry_timer #(
    parameter int DELAY = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);
    localparam int CNT_W = $clog2(DELAY + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    assign fire = busy_q && (cnt_q == '0);

    // Load on start when idle or expiring, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && (!busy_q || fire)) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(DELAY - 1);
        end else if (fire) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R11
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/irq_pin_engine.sv
// Per-pin interrupt request and redelivery engine: NPINS slots, a lowest-pin
// arbiter issuing one delivery per cycle and a shared storm retry timer.
// Assumes routing entries are held outside and line_pin/touch_pin < NPINS.
module irq_pin_engine
    import irq_pin_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int VEC_W       = 8,
    parameter int DEST_W      = 8,
    parameter int STORM_MAX   = 10000,
    parameter int RETRY_DELAY = 1000,
    parameter int PIN_W       = $clog2(NPINS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        cfg_level,
    input  logic [NPINS-1:0]        cfg_mask,
    input  logic [NPINS-1:0]        cfg_destmode,
    input  logic [NPINS*VEC_W-1:0]  cfg_vector,
    input  logic [NPINS*DEST_W-1:0] cfg_dest,
    input  logic                    touch_valid,
    input  logic [PIN_W-1:0]        touch_pin,
    input  logic                    line_valid,
    input  logic [PIN_W-1:0]        line_pin,
    input  logic                    line_level,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vector,
    input  logic                    eoi_level,
    input  logic                    eoi_directed,
    output logic                    res_valid,
    output logic [1:0]              res_code,
    output logic                    deliv_valid,
    output logic [PIN_W-1:0]        deliv_pin,
    output logic [VEC_W-1:0]        deliv_vector,
    output logic [DEST_W-1:0]       deliv_dest,
    output logic                    deliv_destmode,
    output logic                    deliv_level,
    output logic [NPINS-1:0]        pend_irr,
    output logic [NPINS-1:0]        remote_irr
);
    logic [NPINS-1:0] irr, delivered, svc, defer, gnt;
    logic             any, fire;
    logic [PIN_W-1:0] sel;
    res_e             pin_res [NPINS];
    logic             res_valid_q;
    logic [1:0]       res_code_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_slot
        irq_pin_slot #(
            .IDX(i), .PIN_W(PIN_W), .VEC_W(VEC_W), .STORM_MAX(STORM_MAX)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .cfg_level(cfg_level[i]), .cfg_mask(cfg_mask[i]),
            .cfg_vector(cfg_vector[i*VEC_W +: VEC_W]),
            .line_valid(line_valid), .line_pin(line_pin), .line_level(line_level),
            .touch_valid(touch_valid), .touch_pin(touch_pin),
            .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .eoi_level(eoi_level), .eoi_directed(eoi_directed),
            .retry_fire(fire), .grant(gnt[i]),
            .irr(irr[i]), .delivered(delivered[i]), .remote(remote_irr[i]),
            .svc(svc[i]), .defer(defer[i]), .res(pin_res[i])
        );
    end

    irq_pin_arbiter #(.NPINS(NPINS), .PIN_W(PIN_W)) u_arb (
        .req(svc), .gnt(gnt), .any(any), .idx(sel)
    );

    irq_retry_timer #(.DELAY(RETRY_DELAY)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(|defer), .fire(fire)
    );

    // Register the line-change result for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            res_code_q  <= 2'd0;
        end else begin
            res_valid_q <= line_valid;
            res_code_q  <= line_valid ? pin_res[line_pin] : 2'd0;
        end
    end

    assign res_valid      = res_valid_q;
    assign res_code       = res_code_q;
    assign deliv_valid    = any && !cfg_mask[sel];
    assign deliv_pin      = sel;
    assign deliv_vector   = cfg_vector[sel*VEC_W +: VEC_W];
    assign deliv_dest     = cfg_dest[sel*DEST_W +: DEST_W];
    assign deliv_destmode = cfg_destmode[sel];
    assign deliv_level    = cfg_level[sel];
    assign pend_irr       = irr & ~delivered;

    // R5
    no_masked_result_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_level) |=> (res_valid && res_code == 2'd0));
endmodule

// File: tb/irq_pin_engine_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module irq_pin_engine_tb;
    localparam int NP = 4, VW = 8, DW = 4, SMAX = 4, DLY = 12, PW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] cfg_level, cfg_mask, cfg_destmode;
    logic [NP*VW-1:0] cfg_vector;
    logic [NP*DW-1:0] cfg_dest;
    logic touch_valid = 0, line_valid = 0, line_level = 0;
    logic eoi_valid = 0, eoi_level = 0, eoi_directed = 0;
    logic [PW-1:0] touch_pin = 0, line_pin = 0;
    logic [VW-1:0] eoi_vector = 0;
    logic res_valid, deliv_valid, deliv_destmode, deliv_level;
    logic [1:0] res_code;
    logic [PW-1:0] deliv_pin;
    logic [VW-1:0] deliv_vector;
    logic [DW-1:0] deliv_dest;
    logic [NP-1:0] pend_irr, remote_irr;

    always #2.5 clk = ~clk;

    irq_pin_engine #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW),
                     .STORM_MAX(SMAX), .RETRY_DELAY(DLY)) u_dut (.*);

    int total = 0, bad = 0, cycles = 0;
    bit started = 0;
    string tag = "R1 reset";

    // Reference model state.
    bit m_irr[NP], m_del[NP], m_rem[NP], m_svc[NP];
    int m_cnt[NP];
    bit m_busy, m_resv;
    int m_tcnt, m_resc;

    function automatic int vec_of(int p); return 8'h40 + (p == 3 ? 2 : p); endfunction

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            foreach (m_irr[i]) begin
                m_irr[i] = 0; m_del[i] = 0; m_rem[i] = 0; m_svc[i] = 0; m_cnt[i] = 0;
            end
            m_busy = 0; m_tcnt = 0; m_resv = 0; m_resc = 0;
        end else begin
            bit fire, dfr;
            int g;
            fire = m_busy && m_tcnt == 0;
            dfr = 0;
            g = -1;
            for (int i = NP - 1; i >= 0; i--) if (m_svc[i]) g = i;
            if (g >= 0) begin
                m_svc[g] = 0;
                if (!cfg_mask[g]) begin
                    if (cfg_level[g]) m_rem[g] = 1; else m_del[g] = 1;
                end
            end
            m_resv = line_valid;
            m_resc = 0;
            if (line_valid) begin
                int p;
                p = line_pin;
                if (!line_level) m_irr[p] = 0;
                else begin
                    if (cfg_level[p] ? m_rem[p] : m_irr[p]) m_resc = 1;
                    else if (cfg_mask[p]) m_resc = 2;
                    else m_svc[p] = 1;
                    m_irr[p] = 1;
                    if (!cfg_level[p]) m_del[p] = 0;
                end
            end
            if (touch_valid) begin
                m_rem[touch_pin] = 0;
                if (cfg_level[touch_pin] && m_irr[touch_pin]) m_svc[touch_pin] = 1;
            end
            for (int i = 0; i < NP; i++) begin
                if (eoi_valid && eoi_level && !eoi_directed && cfg_level[i]
                    && eoi_vector == cfg_vector[i*VW +: VW]) begin
                    m_rem[i] = 0;
                    if (!cfg_mask[i] && m_irr[i]) begin
                        if (m_cnt[i] == SMAX - 1) begin m_cnt[i] = 0; dfr = 1; end
                        else begin m_cnt[i]++; m_svc[i] = 1; end
                    end else m_cnt[i] = 0;
                end
                if (fire && cfg_level[i] && m_irr[i] && !m_rem[i]) m_svc[i] = 1;
            end
            if (dfr && (!m_busy || fire)) begin m_busy = 1; m_tcnt = DLY - 1; end
            else if (fire) m_busy = 0;
            else if (m_busy) m_tcnt--;
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            int g, ev, epend, erem;
            g = -1;
            for (int i = NP - 1; i >= 0; i--) if (m_svc[i]) g = i;
            ev = (g >= 0) && !cfg_mask[g];
            epend = 0; erem = 0;
            for (int i = 0; i < NP; i++) begin
                epend |= (m_irr[i] && !m_del[i]) << i;
                erem  |= m_rem[i] << i;
            end
            chk(res_valid == m_resv, "res_valid", res_valid, m_resv);
            if (m_resv) chk(res_code == m_resc, "res_code", res_code, m_resc);
            chk(deliv_valid == ev, "deliv_valid", deliv_valid, ev);
            if (ev) begin
                chk(deliv_pin == g, "deliv_pin", deliv_pin, g);
                chk(deliv_vector == vec_of(g), "deliv_vector", deliv_vector, vec_of(g));
                chk(deliv_dest == g + 1, "deliv_dest", deliv_dest, g + 1);
                chk(deliv_level == cfg_level[g], "deliv_level", deliv_level, cfg_level[g]);
            end
            chk(pend_irr == epend, "pend_irr", pend_irr, epend);
            chk(remote_irr == erem, "remote_irr", remote_irr, erem);
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic line(int p, bit l);
        line_valid = 1; line_pin = PW'(p); line_level = l; tick(); line_valid = 0;
    endtask
    task automatic eoi(int v, bit lvl, bit dir);
        eoi_valid = 1; eoi_vector = VW'(v); eoi_level = lvl; eoi_directed = dir;
        tick(); eoi_valid = 0;
    endtask
    task automatic touch(int p);
        touch_valid = 1; touch_pin = PW'(p); tick(); touch_valid = 0;
    endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) tick(); endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5ns * 20000);
        bad++; total++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_level = 4'b1110; cfg_mask = 4'b0000; cfg_destmode = 4'b0101;
        for (int i = 0; i < NP; i++) begin
            cfg_vector[i*VW +: VW] = VW'(vec_of(i));
            cfg_dest[i*DW +: DW] = DW'(i + 1);
        end
        idle(3);
        #1 rst_n = 1; tick();
        tag = "R6 edge delivery";     line(0, 1); idle(2);
        tag = "R3 edge coalesced";    line(0, 1); idle(2);
        tag = "R2 line low";          line(0, 0); idle(1);
        tag = "R3 new edge";          line(0, 1); idle(2);
        tag = "R6 level delivery";    line(1, 1); idle(2);
        tag = "R4 level coalesced";   line(1, 1); idle(2);
        tag = "R8 eoi redelivery";    eoi(8'h41, 1, 0); idle(3);
        tag = "R9 directed eoi";      eoi(8'h41, 1, 1); idle(2);
        tag = "R9 edge eoi";          eoi(8'h41, 0, 0); idle(2);
        tag = "R7 ascending order";   line(2, 1); line(3, 1); idle(2);
        eoi(8'h42, 1, 0); idle(4);
        tag = "R5 masked pin";        cfg_mask[1] = 1; line(1, 0); line(1, 1); idle(2);
        eoi(8'h41, 1, 0); idle(2);
        tag = "R12 entry rewrite";    cfg_mask[1] = 0; touch(1); idle(3);
        tag = "R10 storm deferral";
        for (int k = 0; k < SMAX + 1; k++) begin eoi(8'h41, 1, 0); idle(2); end
        tag = "R11 delayed retry";    idle(DLY + 4);
        tag = "R2/R3/R4/R5/R6/R7/R8/R9/R10/R11/R12 mixed";
        for (int k = 0; k < 1500; k++) begin
            int r;
            r = $urandom % 100;
            if (r < 4) cfg_mask = NP'($urandom % 16 & $urandom % 16);
            line_valid = ($urandom % 100) < 35; line_pin = PW'($urandom);
            line_level = $urandom % 3 != 0;
            touch_valid = ($urandom % 100) < 8; touch_pin = PW'($urandom);
            eoi_valid = ($urandom % 100) < 30;
            eoi_vector = VW'(8'h40 + $urandom % 4);
            eoi_level = $urandom % 5 != 0; eoi_directed = $urandom % 6 == 0;
            tick();
        end
        line_valid = 0; touch_valid = 0; eoi_valid = 0;
        idle(DLY + 4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule